// File: doc/BRIEF.md
# Pull-in and Hold PWM Controller

This block is the digital control core of a high-side load switch for solenoids, valves, relays and heaters. When the enable input is high, the gate command is held fully on for a programmable pull-in interval, so the load gets its full current to close. The command then drops to a pulse-width-modulated hold level, which keeps the load closed while drawing less power. The PWM timebase runs freely and is never restarted by enable. Period, duty and pull-in length are captured into shadow registers only when a PWM period ends, so a change never cuts a pulse short.

Two fault paths protect the switch. An over-current comparator cuts the gate in the cycle it is seen, and the cutoff is re-armed at the next period boundary. A thermal input shuts the output off and holds it off until a separate "cooled" comparator reports, which gives hysteresis. An active-low status flag reports both faults. In master mode the sync output mirrors the on-request so that other switches can follow it. In slave mode the gate follows the sync input instead, and the local pull-in and duty logic are bypassed. All asynchronous inputs pass through two-flop synchronizers.

Top module: `hold_pwm_ctrl`

## Requirements
- R1: After the synchronized enable goes high, the gate is on continuously for pull+2 clock cycles (pull = captured pull-in setting). The PWM hold phase follows.
- R2: In hold, the period counter runs 0..P-1 freely and is not restarted by enable (P = captured period, values below 2 treated as 2). The gate is on while count < (P*D)>>8.
- R3: The duty code D is 8 bits out of 256. Codes below 26 act as 26 and codes above 230 act as 230, so the on-time never decreases as the code rises.
- R4: While the synchronized enable is low, gate_o and sync_o are low whatever the other inputs are.
- R5: While the synchronized over-current input is high, the gate is low in that same cycle. The gate stays blocked until a period boundary passes with over-current low.
- R6: flag_n_o is low while over-current is seen or its block is active, and high again after the re-arming boundary. It is not latched.
- R7: Once over-temperature is seen, the gate is off and flag_n_o is low. Both hold until the cooled input is seen while over-temperature is low.
- R8: In master mode (master_i=1), sync_o is high exactly when enable and the pull-in/PWM logic request the output on. It ignores the over-current and thermal cutoffs.
- R9: In slave mode (master_i=0), the gate follows the synchronized sync_i, qualified by enable and the faults, and sync_o is low.
- R10: A pull-in setting of 0 gives the minimum of 2 full-on cycles. The all-ones setting (1023) keeps the output full-on for as long as enable stays high.
- R11: Period, duty and pull-in settings are captured only at the clock edge that ends a period. Reset loads period 16, duty 128 and pull-in 0.
- R12: Every control input reaches the outputs two clock edges after it changes. A synchronous reset gives gate_o=0, sync_o=0 and flag_n_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Level enable for the load |
| oc_i | input | 1 | Over-current comparator |
| ot_i | input | 1 | Over-temperature comparator |
| cool_i | input | 1 | Die-cooled comparator |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| sync_i | input | 1 | Sync input used in slave mode |
| period_i | input | PER_W | PWM period in clock cycles |
| duty_i | input | 8 | Duty code out of 256 |
| pull_i | input | PULL_W | Pull-in length; all ones = infinite |
| gate_o | output | 1 | Gate command to the power switch |
| sync_o | output | 1 | Mirror of the on-request in master mode |
| flag_n_o | output | 1 | Active-low status flag |

## Verification
A behavioural model runs alongside the design and is compared every cycle. It covers several settings: pull-in lengths of 5, 0 and infinite; periods changed in the middle of a period; and duty codes below, inside and above the clamp range. These show whether the pull-in count, the shadow capture and the clamping are right. Windowed on-cycle counts over one full period tell a correct duty product apart from an off-by-one compare. Over-current and thermal pulses land at arbitrary PWM phases, which separates an immediate cutoff, re-arming at the boundary and thermal hysteresis, and shows that the sync mirror is not affected by faults. A slave run toggles sync_i to confirm that the gate follows it with the local duty bypassed.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int DUTY_W  = 8;
    localparam int DUTY_LO = 26;
    localparam int DUTY_HI = 230;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PULL = 2'd1,
        PH_HOLD = 2'd2
    } phase_t;

    typedef struct packed {
        logic en;
        logic oc;
        logic ot;
        logic cool;
        logic sync;
        logic mst;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [DUTY_W-1:0] clamp_duty(input logic [DUTY_W-1:0] d);
        if (d < DUTY_W'(DUTY_LO))      return DUTY_W'(DUTY_LO);
        else if (d > DUTY_W'(DUTY_HI)) return DUTY_W'(DUTY_HI);
        else                           return d;
    endfunction

endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/hpc_timebase.sv
module hpc_timebase
    import hpc_pkg::*;
#(
    parameter int PER_W    = 8,
    parameter int PULL_W   = 10,
    parameter int PER_RST  = 16,
    parameter int DUTY_RST = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PER_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [PULL_W-1:0] pull_i,
    output logic              wrap_o,
    output logic              pwm_on_o,
    output logic [PULL_W-1:0] pull_q_o
);
    localparam int PROD_W = PER_W + DUTY_W;

    logic [PER_W-1:0]  cnt_q;
    logic [PER_W-1:0]  per_q;
    logic [DUTY_W-1:0] duty_q;
    logic [PULL_W-1:0] pull_q;
    logic [PER_W-1:0]  per_fix;
    logic [PROD_W-1:0] prod;
    logic [PER_W-1:0]  on_len;

    assign per_fix = (period_i < PER_W'(2)) ? PER_W'(2) : period_i;
    assign wrap_o  = (cnt_q == per_q - PER_W'(1));
    assign prod    = {{DUTY_W{1'b0}}, per_q} * {{PER_W{1'b0}}, duty_q};
    assign on_len  = prod[PROD_W-1:DUTY_W];
    assign pwm_on_o = (cnt_q < on_len);
    assign pull_q_o = pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= PER_W'(PER_RST);
            duty_q <= DUTY_W'(DUTY_RST);
            pull_q <= '0;
        end else if (wrap_o) begin
            cnt_q  <= '0;
            per_q  <= per_fix;
            duty_q <= clamp_duty(duty_i);
            pull_q <= pull_i;
        end else begin
            cnt_q  <= cnt_q + PER_W'(1);
        end
    end
endmodule

// File: rtl/hpc_phase.sv
module hpc_phase
    import hpc_pkg::*;
#(
    parameter int PULL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_s,
    input  logic [PULL_W-1:0] pull_q,
    output phase_t            phase_o
);
    phase_t            ph_q;
    logic [PULL_W-1:0] left_q;
    logic              endless_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            left_q    <= '0;
            endless_q <= 1'b0;
        end else if (!en_s) begin
            ph_q      <= PH_IDLE;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    ph_q      <= PH_PULL;
                    left_q    <= pull_q;
                    endless_q <= (pull_q == '1);
                end
                PH_PULL: begin
                    if (!endless_q) begin
                        if (left_q == '0) ph_q <= PH_HOLD;
                        else              left_q <= left_q - PULL_W'(1);
                    end
                end
                default: ph_q <= PH_HOLD;
            endcase
        end
    end

    assign phase_o = ph_q;
endmodule

// File: rtl/hpc_guard.sv
module hpc_guard (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    input  logic ot_s,
    input  logic cool_s,
    input  logic wrap,
    output logic therm_o,
    output logic ocb_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            therm_o <= 1'b0;
            ocb_o   <= 1'b0;
        end else begin
            if (ot_s)        therm_o <= 1'b1;
            else if (cool_s) therm_o <= 1'b0;
            if (oc_s)        ocb_o   <= 1'b1;
            else if (wrap)   ocb_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/hold_pwm_ctrl.sv
module hold_pwm_ctrl
    import hpc_pkg::*;
#(
    parameter int PER_W  = 8,
    parameter int PULL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              oc_i,
    input  logic              ot_i,
    input  logic              cool_i,
    input  logic              master_i,
    input  logic              sync_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [PULL_W-1:0] pull_i,
    output logic              gate_o,
    output logic              sync_o,
    output logic              flag_n_o
);
    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [CTL_W-1:0]  ctl_vec;
    logic              en_s, oc_s, ot_s, cool_s, sy_s, mst_s;
    logic              wrap, pwm_on, therm_q, ocb_q, req;
    logic [PULL_W-1:0] pull_q;
    phase_t            phase;

    assign ctl_raw.en   = en_i;
    assign ctl_raw.oc   = oc_i;
    assign ctl_raw.ot   = ot_i;
    assign ctl_raw.cool = cool_i;
    assign ctl_raw.sync = sync_i;
    assign ctl_raw.mst  = master_i;

    hpc_sync #(.W(CTL_W)) sync_u (
        .clk(clk), .rst(rst), .d_i(ctl_raw), .q_o(ctl_vec)
    );

    assign ctl_s  = ctl_t'(ctl_vec);
    assign en_s   = ctl_s.en;
    assign oc_s   = ctl_s.oc;
    assign ot_s   = ctl_s.ot;
    assign cool_s = ctl_s.cool;
    assign sy_s   = ctl_s.sync;
    assign mst_s  = ctl_s.mst;

    hpc_timebase #(.PER_W(PER_W), .PULL_W(PULL_W)) tb_u (
        .clk(clk), .rst(rst), .period_i(period_i), .duty_i(duty_i),
        .pull_i(pull_i), .wrap_o(wrap), .pwm_on_o(pwm_on), .pull_q_o(pull_q)
    );

    hpc_phase #(.PULL_W(PULL_W)) ph_u (
        .clk(clk), .rst(rst), .en_s(en_s), .pull_q(pull_q), .phase_o(phase)
    );

    hpc_guard guard_u (
        .clk(clk), .rst(rst), .oc_s(oc_s), .ot_s(ot_s), .cool_s(cool_s),
        .wrap(wrap), .therm_o(therm_q), .ocb_o(ocb_q)
    );

    // On-request: local pull-in/PWM in master mode, sync pin in slave mode
    assign req      = en_s && (mst_s ? ((phase != PH_HOLD) || pwm_on) : sy_s);
    assign gate_o   = req && !therm_q && !ocb_q && !oc_s;
    assign sync_o   = mst_s && req;
    assign flag_n_o = !(therm_q || ocb_q || oc_s);
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker (
    input logic clk,
    input logic rst,
    input logic en_s,
    input logic oc_s,
    input logic ot_s,
    input logic mst_s,
    input logic wrap,
    input logic ocb_q,
    input logic gate_o,
    input logic sync_o,
    input logic flag_n_o
);
    assert_en_gates_R4: assert property (@(posedge clk) disable iff (rst)
        !en_s |-> (!gate_o && !sync_o));

    assert_oc_cut_R5: assert property (@(posedge clk) disable iff (rst)
        oc_s |-> !gate_o);

    assert_rearm_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ocb_q) |-> $past(wrap));

    assert_oc_flag_R6: assert property (@(posedge clk) disable iff (rst)
        oc_s |-> !flag_n_o);

    assert_therm_flag_R7: assert property (@(posedge clk) disable iff (rst)
        ot_s |=> !flag_n_o);

    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !mst_s |-> !sync_o);
endmodule

bind hold_pwm_ctrl hpc_checker chk_i (
    .clk(clk), .rst(rst), .en_s(en_s), .oc_s(oc_s), .ot_s(ot_s),
    .mst_s(mst_s), .wrap(wrap), .ocb_q(ocb_q), .gate_o(gate_o),
    .sync_o(sync_o), .flag_n_o(flag_n_o)
);

// File: tb/hold_pwm_ctrl_tb.sv
module hold_pwm_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 0, oc = 0, ot = 0, cool = 0, mst = 1, syi = 0;
    logic [7:0] period = 8'd20;
    logic [7:0] duty = 8'd128;
    logic [9:0] pull = 10'd5;
    logic       gate, syo, flag_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R12";

    always #4 clk = ~clk;

    hold_pwm_ctrl dut_i (
        .clk(clk), .rst(rst), .en_i(en), .oc_i(oc), .ot_i(ot), .cool_i(cool),
        .master_i(mst), .sync_i(syi), .period_i(period), .duty_i(duty),
        .pull_i(pull), .gate_o(gate), .sync_o(syo), .flag_n_o(flag_n)
    );

    // Behavioural reference model
    int e1, e2, o1, o2, t1, t2, c1, c2, y1, y2, m1, m2;
    int cnt, per, dty, pl, st, dc, inf, th, ob;

    always @(posedge clk) begin
        int w;
        if (rst) begin
            e1 = 0; e2 = 0; o1 = 0; o2 = 0; t1 = 0; t2 = 0;
            c1 = 0; c2 = 0; y1 = 0; y2 = 0; m1 = 0; m2 = 0;
            cnt = 0; per = 16; dty = 128; pl = 0; st = 0; dc = 0; inf = 0;
            th = 0; ob = 0;
        end else begin
            w = (cnt == per - 1) ? 1 : 0;
            if (e2 == 0) st = 0;
            else if (st == 0) begin st = 1; dc = pl; inf = (pl == 1023) ? 1 : 0; end
            else if (st == 1 && inf == 0) begin
                if (dc == 0) st = 2; else dc = dc - 1;
            end
            if (t2 != 0) th = 1; else if (c2 != 0) th = 0;
            if (o2 != 0) ob = 1; else if (w != 0) ob = 0;
            if (w != 0) begin
                cnt = 0;
                per = (int'(period) < 2) ? 2 : int'(period);
                dty = (int'(duty) < 26) ? 26 : ((int'(duty) > 230) ? 230 : int'(duty));
                pl  = int'(pull);
            end else cnt = cnt + 1;
            e2 = e1; e1 = int'(en);   o2 = o1; o1 = int'(oc);
            t2 = t1; t1 = int'(ot);   c2 = c1; c1 = int'(cool);
            y2 = y1; y1 = int'(syi);  m2 = m1; m1 = int'(mst);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int req, mg, ms, mf, pwm;
        if (!rst && !finished) begin
            pwm = (cnt < (per * dty) / 256) ? 1 : 0;
            if (m2 != 0) req = (e2 != 0 && (st != 2 || pwm != 0)) ? 1 : 0;
            else         req = (e2 != 0 && y2 != 0) ? 1 : 0;
            mg = (req != 0 && th == 0 && ob == 0 && o2 == 0) ? 1 : 0;
            ms = (m2 != 0 && req != 0) ? 1 : 0;
            mf = (th == 0 && ob == 0 && o2 == 0) ? 1 : 0;
            chk(int'(gate) == mg, {cur_req, " gate"}, int'(gate), mg);
            chk(int'(syo) == ms, {cur_req, " sync_o"}, int'(syo), ms);
            chk(int'(flag_n) == mf, {cur_req, " flag_n"}, int'(flag_n), mf);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_gate(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(gate);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int c;
        cyc(4);
        // R12: reset state
        chk(gate == 1'b0, "R12 reset gate", int'(gate), 0);
        chk(syo == 1'b0, "R12 reset sync_o", int'(syo), 0);
        chk(flag_n == 1'b1, "R12 reset flag_n", int'(flag_n), 1);
        rst = 1'b0;
        cyc(40);

        // R1: pull-in then PWM, two-edge input latency (R12)
        cur_req = "R1";
        en = 1'b1;
        cyc(2);
        chk(gate == 1'b1, "R1 gate on after sync", int'(gate), 1);
        cyc(200);

        // R2/R3: duty product and clamp over one full period
        cur_req = "R3";
        period = 8'd100; duty = 8'd0;
        cyc(250);
        count_gate(100, c);
        chk(c == 10, "R3 low clamp on-cycles", c, 10);
        duty = 8'd255;
        cyc(120);
        count_gate(100, c);
        chk(c == 89, "R3 high clamp on-cycles", c, 89);
        cur_req = "R2";
        duty = 8'd128;
        cyc(120);
        count_gate(100, c);
        chk(c == 50, "R2 mid duty on-cycles", c, 50);

        // R11: settings change mid-period
        cur_req = "R11";
        cyc(33);
        period = 8'd37; duty = 8'd200;
        cyc(200);

        // R4: enable low dominates
        cur_req = "R4";
        en = 1'b0; syi = 1'b1;
        cyc(3);
        count_gate(50, c);
        chk(c == 0, "R4 gate while disabled", c, 0);
        chk(syo == 1'b0, "R4 sync_o while disabled", int'(syo), 0);
        syi = 1'b0;

        // R10: minimum and infinite pull-in
        cur_req = "R10";
        pull = 10'd0;
        cyc(80);
        en = 1'b1;
        cyc(100);
        en = 1'b0;
        pull = 10'd1023;
        cyc(80);
        en = 1'b1;
        cyc(3);
        count_gate(300, c);
        chk(c == 300, "R10 infinite pull-in", c, 300);
        en = 1'b0;
        pull = 10'd0;
        cyc(80);
        en = 1'b1;
        cyc(60);

        // R5/R6: over-current cut and re-arm
        cur_req = "R5";
        oc = 1'b1;
        cyc(2);
        chk(gate == 1'b0, "R5 gate cut by over-current", int'(gate), 0);
        chk(flag_n == 1'b0, "R6 flag low on over-current", int'(flag_n), 0);
        cyc(1);
        oc = 1'b0;
        cur_req = "R6";
        cyc(120);
        chk(flag_n == 1'b1, "R6 flag restored after boundary", int'(flag_n), 1);

        // R8: sync mirror ignores over-current
        cur_req = "R8";
        cyc(11);
        oc = 1'b1;
        cyc(30);
        oc = 1'b0;
        cyc(100);

        // R7: thermal hysteresis
        cur_req = "R7";
        ot = 1'b1;
        cyc(4);
        ot = 1'b0;
        cyc(60);
        count_gate(37, c);
        chk(c == 0, "R7 gate off until cooled", c, 0);
        chk(flag_n == 1'b0, "R7 flag held low", int'(flag_n), 0);
        cool = 1'b1;
        cyc(3);
        chk(flag_n == 1'b1, "R7 flag released by cool", int'(flag_n), 1);
        cool = 1'b0;
        cyc(80);

        // R9: slave mode follows sync_i
        cur_req = "R9";
        mst = 1'b0;
        cyc(3);
        syi = 1'b1;
        cyc(2);
        chk(gate == 1'b1, "R9 gate follows sync high", int'(gate), 1);
        chk(syo == 1'b0, "R9 sync_o quiet in slave", int'(syo), 0);
        syi = 1'b0;
        cyc(2);
        chk(gate == 1'b0, "R9 gate follows sync low", int'(gate), 0);
        for (int k = 0; k < 60; k++) begin
            syi = ((k % 7) < 3) ? 1'b1 : 1'b0;
            cyc(1);
        end
        cyc(10);
        finish_run();
    end
endmodule